// File: doc/BRIEF.md
# Tagged Translation Cache with Global Entries

This block is a small, fully associative cache of address translations. Each live entry pairs a virtual page number (the address bits above the 4 KB page offset) with a physical frame number, a few permission flags, an address-space tag and a global bit. A lookup is purely combinational. It takes a virtual address and the current address-space tag, and returns hit, frame number, flags and the global bit of the matching entry.

Entries are written through a fill port. A fill places the translation into an entry that already holds the same page and tag. Failing that, it uses the lowest-numbered empty entry. Failing that, it uses a round-robin victim.

Three invalidation controls remove entries. The first is a page-directory base write. It clears every non-global entry when tagging is off, and does nothing when tagging is on, because then a process switch only changes the current tag. The second is a single-page flush that targets one page within one address space. The third is a flush of everything.

Top module: `xc_top`

## Requirements
- R1: After reset every entry is empty, so every lookup gives hit low.
- R2: After a fill, a lookup with the same page number and tag hits in the next cycle and returns the filled frame number, flags and global bit.
- R3: With tagging enabled (tag_en_i high), a non-global entry hits only if the lookup tag equals its stored tag. With tagging disabled, the tag is not compared.
- R4: A fill whose page number and tag both equal those of a live entry overwrites that entry in place. Every other entry is left intact.
- R5: A fill with no in-place match goes to the lowest-numbered empty entry when one exists. Otherwise it goes to the entry named by a round-robin pointer. The pointer starts at entry 0, advances by one (wrapping) only on such victim fills, and moves for nothing else.
- R6: A single-page flush removes only entries whose stored page number and stored tag both equal the request.
- R7: A global entry hits for any lookup tag.
- R8: A directory-base write with tagging enabled removes no entry.
- R9: A directory-base write with tagging disabled removes every non-global entry and keeps global ones.
- R10: A flush-all removes every entry, global ones included, in one cycle.
- R11: In a cycle that carries any entry-removing request (flush-all, single-page flush, or untagged directory-base write), the fill is dropped. Flush-all takes precedence over the untagged directory-base write, which takes precedence over the single-page flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tag_en_i | input | 1 | Address-space tagging enable |
| lk_vaddr_i | input | VA_W | Lookup virtual address |
| lk_asid_i | input | ASID_W | Current address-space tag |
| lk_hit_o | output | 1 | Lookup hit |
| lk_pfn_o | output | PA_W-12 | Frame number of the hit |
| lk_flags_o | output | FLAG_W | Permission flags of the hit |
| lk_global_o | output | 1 | Global bit of the hit |
| fill_valid_i | input | 1 | Fill request |
| fill_vpn_i | input | VA_W-12 | Fill page number |
| fill_asid_i | input | ASID_W | Fill tag |
| fill_pfn_i | input | PA_W-12 | Fill frame number |
| fill_flags_i | input | FLAG_W | Fill flags |
| fill_global_i | input | 1 | Fill global bit |
| dirbase_wr_i | input | 1 | Directory-base write |
| flush_page_i | input | 1 | Single-page flush request |
| flush_vpn_i | input | VA_W-12 | Page number to flush |
| flush_asid_i | input | ASID_W | Tag to flush |
| flush_all_i | input | 1 | Flush every entry |

## Verification
The properties assume that no two live entries share a page number. Under that assumption a lookup has at most one candidate, so a fill or flush fully decides the result of the next lookup. The stimulus respects it by giving every fill a distinct page number. The only repeated fill is the deliberate in-place overwrite, which keeps both page and tag. Frame numbers and flags are computed from the page number, so the expected values follow from arithmetic. The round-robin and empty-slot choices are observed through which earlier pages stop hitting.

// File: rtl/xc_pkg.sv
package xc_pkg;
  localparam int unsigned PAGE_SHIFT = 12;

  typedef enum logic [1:0] {
    INV_NONE,
    INV_PAGE,
    INV_NONGLB,
    INV_ALL
  } inv_kind_e;
endpackage

// File: rtl/xc_entry_cmp.sv
module xc_entry_cmp #(
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned ASID_W = 8
) (
  input  logic              e_valid_i,
  input  logic              e_global_i,
  input  logic [VPN_W-1:0]  e_vpn_i,
  input  logic [ASID_W-1:0] e_asid_i,
  input  logic              tag_en_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [VPN_W-1:0]  fl_vpn_i,
  input  logic [ASID_W-1:0] fl_asid_i,
  output logic              lk_match_o,
  output logic              fill_match_o,
  output logic              fl_match_o
);
  logic lk_tag_ok;

  assign lk_tag_ok    = !tag_en_i || e_global_i || (e_asid_i == lk_asid_i);
  assign lk_match_o   = e_valid_i && (e_vpn_i == lk_vpn_i) && lk_tag_ok;
  assign fill_match_o = e_valid_i && (e_vpn_i == fill_vpn_i) && (e_asid_i == fill_asid_i);
  assign fl_match_o   = e_valid_i && (e_vpn_i == fl_vpn_i) && (e_asid_i == fl_asid_i);
endmodule

// File: rtl/xc_victim.sv
module xc_victim #(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fill_go_i,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [ENTRIES-1:0] inplace_i,
  output logic [ENTRIES-1:0] wr_oh_o
);
  logic [IDX_W-1:0]   rr_q;
  logic [ENTRIES-1:0] inplace_oh, free_oh, rr_oh;
  logic               use_rr;

  always_comb begin
    inplace_oh = '0;
    free_oh    = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (inplace_i[i]) begin
        inplace_oh    = '0;
        inplace_oh[i] = 1'b1;
      end
      if (!valid_i[i]) begin
        free_oh    = '0;
        free_oh[i] = 1'b1;
      end
    end
  end

  always_comb begin
    rr_oh = '0;
    rr_oh[rr_q] = 1'b1;
  end

  assign use_rr = fill_go_i && !(|inplace_i) && (&valid_i);

  always_comb begin
    wr_oh_o = '0;
    if (fill_go_i) begin
      if (|inplace_i)      wr_oh_o = inplace_oh;
      else if (!(&valid_i)) wr_oh_o = free_oh;
      else                 wr_oh_o = rr_oh;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (use_rr) rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/xc_onehot_mux.sv
module xc_onehot_mux #(
  parameter int unsigned N = 64,
  parameter int unsigned W = 8
) (
  input  logic [N-1:0]   sel_i,
  input  logic [N*W-1:0] data_i,
  output logic           any_o,
  output logic [W-1:0]   data_o
);
  assign any_o = |sel_i;

  // lowest index wins
  always_comb begin
    data_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (sel_i[i]) data_o = data_i[i*W +: W];
    end
  end
endmodule

// File: rtl/xc_top.sv
module xc_top
  import xc_pkg::*;
#(
  parameter int unsigned VA_W    = 32,
  parameter int unsigned PA_W    = 32,
  parameter int unsigned ASID_W  = 8,
  parameter int unsigned FLAG_W  = 4,
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned VPN_W  = VA_W - PAGE_SHIFT,
  localparam int unsigned PFN_W  = PA_W - PAGE_SHIFT,
  localparam int unsigned PAY_W  = PFN_W + FLAG_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tag_en_i,
  input  logic [VA_W-1:0]   lk_vaddr_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic              lk_hit_o,
  output logic [PFN_W-1:0]  lk_pfn_o,
  output logic [FLAG_W-1:0] lk_flags_o,
  output logic              lk_global_o,
  input  logic              fill_valid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic [FLAG_W-1:0] fill_flags_i,
  input  logic              fill_global_i,
  input  logic              dirbase_wr_i,
  input  logic              flush_page_i,
  input  logic [VPN_W-1:0]  flush_vpn_i,
  input  logic [ASID_W-1:0] flush_asid_i,
  input  logic              flush_all_i
);
  logic [ENTRIES-1:0] valid_q, glb_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q  [ENTRIES];
  logic [FLAG_W-1:0]  flg_q  [ENTRIES];

  logic [ENTRIES-1:0]       lk_m, fill_m, fl_m, wr_oh;
  logic [ENTRIES*PAY_W-1:0] pay_flat;
  logic [PAY_W-1:0]         pay_sel;
  logic [VPN_W-1:0]         lk_vpn;
  inv_kind_e                inv;
  logic                     fill_go;

  assign lk_vpn = lk_vaddr_i[VA_W-1:PAGE_SHIFT];

  always_comb begin
    if (flush_all_i)                    inv = INV_ALL;
    else if (dirbase_wr_i && !tag_en_i) inv = INV_NONGLB;
    else if (flush_page_i)              inv = INV_PAGE;
    else                                inv = INV_NONE;
  end

  assign fill_go = fill_valid_i && (inv == INV_NONE);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    xc_entry_cmp #(.VPN_W(VPN_W), .ASID_W(ASID_W)) i_cmp (
      .e_valid_i   (valid_q[g]),
      .e_global_i  (glb_q[g]),
      .e_vpn_i     (vpn_q[g]),
      .e_asid_i    (asid_q[g]),
      .tag_en_i    (tag_en_i),
      .lk_vpn_i    (lk_vpn),
      .lk_asid_i   (lk_asid_i),
      .fill_vpn_i  (fill_vpn_i),
      .fill_asid_i (fill_asid_i),
      .fl_vpn_i    (flush_vpn_i),
      .fl_asid_i   (flush_asid_i),
      .lk_match_o  (lk_m[g]),
      .fill_match_o(fill_m[g]),
      .fl_match_o  (fl_m[g])
    );
    assign pay_flat[g*PAY_W +: PAY_W] = {pfn_q[g], flg_q[g], glb_q[g]};

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        glb_q[g]   <= 1'b0;
        vpn_q[g]   <= '0;
        asid_q[g]  <= '0;
        pfn_q[g]   <= '0;
        flg_q[g]   <= '0;
      end else begin
        unique case (inv)
          INV_ALL:    valid_q[g] <= 1'b0;
          INV_NONGLB: if (!glb_q[g]) valid_q[g] <= 1'b0;
          INV_PAGE:   if (fl_m[g]) valid_q[g] <= 1'b0;
          default: if (wr_oh[g]) begin
            valid_q[g] <= 1'b1;
            glb_q[g]   <= fill_global_i;
            vpn_q[g]   <= fill_vpn_i;
            asid_q[g]  <= fill_asid_i;
            pfn_q[g]   <= fill_pfn_i;
            flg_q[g]   <= fill_flags_i;
          end
        endcase
      end
    end
  end

  xc_victim #(.ENTRIES(ENTRIES)) i_victim (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fill_go_i(fill_go),
    .valid_i  (valid_q),
    .inplace_i(fill_m),
    .wr_oh_o  (wr_oh)
  );

  xc_onehot_mux #(.N(ENTRIES), .W(PAY_W)) i_mux (
    .sel_i (lk_m),
    .data_i(pay_flat),
    .any_o (lk_hit_o),
    .data_o(pay_sel)
  );

  assign {lk_pfn_o, lk_flags_o, lk_global_o} = pay_sel;
endmodule

// File: rtl/xc_checker.sv
module xc_checker #(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PA_W   = 32,
  parameter int unsigned ASID_W = 8,
  localparam int unsigned VPN_W = VA_W - 12,
  localparam int unsigned PFN_W = PA_W - 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tag_en_i,
  input logic [VA_W-1:0]   lk_vaddr_i,
  input logic [ASID_W-1:0] lk_asid_i,
  input logic              lk_hit_o,
  input logic [PFN_W-1:0]  lk_pfn_o,
  input logic              lk_global_o,
  input logic              fill_valid_i,
  input logic [VPN_W-1:0]  fill_vpn_i,
  input logic [ASID_W-1:0] fill_asid_i,
  input logic [PFN_W-1:0]  fill_pfn_i,
  input logic              dirbase_wr_i,
  input logic              flush_page_i,
  input logic              flush_all_i
);
  logic [VPN_W-1:0] lk_vpn;
  logic             no_inv;

  assign lk_vpn = lk_vaddr_i[VA_W-1:12];
  assign no_inv = !flush_all_i && !flush_page_i && !(dirbase_wr_i && !tag_en_i);

  p_flush_all_empties_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> !lk_hit_o);

  p_untagged_dirbase_keeps_global_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dirbase_wr_i && !tag_en_i && !flush_all_i) |=> (!lk_hit_o || lk_global_o));

  p_fill_visible_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && no_inv) |=>
      (!(lk_vpn == $past(fill_vpn_i) && lk_asid_i == $past(fill_asid_i))
       || (lk_hit_o && lk_pfn_o == $past(fill_pfn_i))));

  p_tagged_dirbase_keeps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dirbase_wr_i && tag_en_i && !flush_all_i && !flush_page_i && !fill_valid_i && lk_hit_o) |=>
      (!($stable(lk_vaddr_i) && $stable(lk_asid_i) && $stable(tag_en_i)) || lk_hit_o));

  p_fill_dropped_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_all_i && fill_valid_i) |=> !lk_hit_o);
endmodule

bind xc_top xc_checker #(.VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W)) i_xc_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tag_en_i     (tag_en_i),
  .lk_vaddr_i   (lk_vaddr_i),
  .lk_asid_i    (lk_asid_i),
  .lk_hit_o     (lk_hit_o),
  .lk_pfn_o     (lk_pfn_o),
  .lk_global_o  (lk_global_o),
  .fill_valid_i (fill_valid_i),
  .fill_vpn_i   (fill_vpn_i),
  .fill_asid_i  (fill_asid_i),
  .fill_pfn_i   (fill_pfn_i),
  .dirbase_wr_i (dirbase_wr_i),
  .flush_page_i (flush_page_i),
  .flush_all_i  (flush_all_i)
);

// File: tb/test_xc_top.sv
`timescale 1ns/1ps
module test_xc_top;
  localparam int unsigned VA_W = 32, PA_W = 32, ASID_W = 4, FLAG_W = 4, ENTRIES = 8;
  localparam int unsigned VPN_W = VA_W - 12, PFN_W = PA_W - 12;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic tag_en_i = 1'b1;
  logic [VA_W-1:0] lk_vaddr_i = '0;
  logic [ASID_W-1:0] lk_asid_i = '0;
  logic lk_hit_o, lk_global_o;
  logic [PFN_W-1:0] lk_pfn_o;
  logic [FLAG_W-1:0] lk_flags_o;
  logic fill_valid_i = 1'b0, fill_global_i = 1'b0;
  logic [VPN_W-1:0] fill_vpn_i = '0, flush_vpn_i = '0;
  logic [ASID_W-1:0] fill_asid_i = '0, flush_asid_i = '0;
  logic [PFN_W-1:0] fill_pfn_i = '0;
  logic [FLAG_W-1:0] fill_flags_i = '0;
  logic dirbase_wr_i = 1'b0, flush_page_i = 1'b0, flush_all_i = 1'b0;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  xc_top #(.VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W), .FLAG_W(FLAG_W), .ENTRIES(ENTRIES)) i_xc_top (.*);

  function automatic logic [PFN_W-1:0] pfn_of(input logic [VPN_W-1:0] v);
    return PFN_W'(32'h5000 + v * 3);
  endfunction

  task automatic fill(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                      input logic [PFN_W-1:0] p, input logic g);
    @(negedge clk_i);
    fill_valid_i = 1'b1; fill_vpn_i = v; fill_asid_i = a;
    fill_pfn_i = p; fill_flags_i = v[3:0]; fill_global_i = g;
    @(negedge clk_i);
    fill_valid_i = 1'b0; fill_global_i = 1'b0;
  endtask

  task automatic pulse(input int kind, input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a);
    @(negedge clk_i);
    flush_vpn_i = v; flush_asid_i = a;
    if (kind == 0) dirbase_wr_i = 1'b1;
    if (kind == 1) flush_page_i = 1'b1;
    if (kind == 2) flush_all_i = 1'b1;
    @(negedge clk_i);
    dirbase_wr_i = 1'b0; flush_page_i = 1'b0; flush_all_i = 1'b0;
  endtask

  task automatic chk(input string req, input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                     input logic ten, input logic exp_hit, input logic [PFN_W-1:0] exp_pfn,
                     input logic exp_glb);
    lk_vaddr_i = {v, 12'habc}; lk_asid_i = a; tag_en_i = ten;
    #1;
    checks++;
    if (lk_hit_o !== exp_hit ||
        (exp_hit && (lk_pfn_o !== exp_pfn || lk_flags_o !== v[3:0] || lk_global_o !== exp_glb))) begin
      errors++;
      $display("FAIL %s vpn=%h hit=%b pfn=%h flg=%h glb=%b exp hit=%b pfn=%h flg=%h glb=%b",
               req, v, lk_hit_o, lk_pfn_o, lk_flags_o, lk_global_o, exp_hit, exp_pfn, v[3:0], exp_glb);
    end
    tag_en_i = 1'b1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: empty after reset
    for (int v = 0; v < 4; v++) chk("R1", VPN_W'(32'h100 + v), 4'd1, 1'b1, 1'b0, '0, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", 20'h100, 4'd1, 1'b0, 1'b0, '0, 1'b0);

    // R2: fill all entries, each visible with its data
    for (int i = 0; i < ENTRIES; i++) fill(VPN_W'(32'h100 + i), 4'd1, pfn_of(VPN_W'(32'h100 + i)), 1'b0);
    for (int i = 0; i < ENTRIES; i++)
      chk("R2", VPN_W'(32'h100 + i), 4'd1, 1'b1, 1'b1, pfn_of(VPN_W'(32'h100 + i)), 1'b0);

    // R3: tag compare only when tagging enabled
    chk("R3", 20'h105, 4'd2, 1'b1, 1'b0, '0, 1'b0);
    chk("R3", 20'h105, 4'd2, 1'b0, 1'b1, pfn_of(20'h105), 1'b0);

    // R4: in-place overwrite, nothing evicted
    fill(20'h103, 4'd1, pfn_of(20'h103) + 1'b1, 1'b0);
    chk("R4", 20'h103, 4'd1, 1'b1, 1'b1, pfn_of(20'h103) + 1'b1, 1'b0);
    for (int i = 0; i < ENTRIES; i++)
      if (i != 3) chk("R4", VPN_W'(32'h100 + i), 4'd1, 1'b1, 1'b1, pfn_of(VPN_W'(32'h100 + i)), 1'b0);

    // R5: round robin from entry 0, then entry 1
    fill(20'h200, 4'd1, pfn_of(20'h200), 1'b0);
    chk("R5", 20'h100, 4'd1, 1'b1, 1'b0, '0, 1'b0);
    chk("R5", 20'h101, 4'd1, 1'b1, 1'b1, pfn_of(20'h101), 1'b0);
    fill(20'h201, 4'd1, pfn_of(20'h201), 1'b0);
    chk("R5", 20'h101, 4'd1, 1'b1, 1'b0, '0, 1'b0);
    chk("R5", 20'h200, 4'd1, 1'b1, 1'b1, pfn_of(20'h200), 1'b0);
    chk("R5", 20'h201, 4'd1, 1'b1, 1'b1, pfn_of(20'h201), 1'b0);

    // R6: single-page flush needs both page and tag
    pulse(1, 20'h102, 4'd1);
    chk("R6", 20'h102, 4'd1, 1'b1, 1'b0, '0, 1'b0);
    chk("R6", 20'h104, 4'd1, 1'b1, 1'b1, pfn_of(20'h104), 1'b0);
    pulse(1, 20'h105, 4'd2);
    chk("R6", 20'h105, 4'd1, 1'b1, 1'b1, pfn_of(20'h105), 1'b0);

    // R5: empty slot (entry 2) preferred over victim
    fill(20'h300, 4'd1, pfn_of(20'h300), 1'b0);
    chk("R5", 20'h300, 4'd1, 1'b1, 1'b1, pfn_of(20'h300), 1'b0);
    for (int i = 4; i < ENTRIES; i++)
      chk("R5", VPN_W'(32'h100 + i), 4'd1, 1'b1, 1'b1, pfn_of(VPN_W'(32'h100 + i)), 1'b0);
    chk("R5", 20'h200, 4'd1, 1'b1, 1'b1, pfn_of(20'h200), 1'b0);

    // R7: global fill evicts entry 2 (pointer at 2), hits under any tag
    fill(20'h400, 4'd3, pfn_of(20'h400), 1'b1);
    chk("R5", 20'h300, 4'd1, 1'b1, 1'b0, '0, 1'b0);
    chk("R7", 20'h400, 4'd7, 1'b1, 1'b1, pfn_of(20'h400), 1'b1);
    chk("R7", 20'h400, 4'd0, 1'b1, 1'b1, pfn_of(20'h400), 1'b1);

    // R8: tagged directory-base write flushes nothing
    @(negedge clk_i); tag_en_i = 1'b1; dirbase_wr_i = 1'b1;
    @(negedge clk_i); dirbase_wr_i = 1'b0;
    chk("R8", 20'h104, 4'd1, 1'b1, 1'b1, pfn_of(20'h104), 1'b0);
    chk("R8", 20'h201, 4'd1, 1'b1, 1'b1, pfn_of(20'h201), 1'b0);
    chk("R8", 20'h400, 4'd9, 1'b1, 1'b1, pfn_of(20'h400), 1'b1);

    // R9: untagged directory-base write keeps only globals
    @(negedge clk_i); tag_en_i = 1'b0; dirbase_wr_i = 1'b1;
    @(negedge clk_i); dirbase_wr_i = 1'b0; tag_en_i = 1'b1;
    chk("R9", 20'h104, 4'd1, 1'b1, 1'b0, '0, 1'b0);
    chk("R9", 20'h200, 4'd1, 1'b0, 1'b0, '0, 1'b0);
    chk("R9", 20'h400, 4'd9, 1'b1, 1'b1, pfn_of(20'h400), 1'b1);

    // R10: flush-all removes global too
    pulse(2, '0, '0);
    chk("R10", 20'h400, 4'd3, 1'b1, 1'b0, '0, 1'b0);

    // R11: fill dropped alongside flush-all
    @(negedge clk_i);
    flush_all_i = 1'b1; fill_valid_i = 1'b1; fill_vpn_i = 20'h500; fill_asid_i = 4'd1;
    fill_pfn_i = pfn_of(20'h500); fill_flags_i = 4'h0; fill_global_i = 1'b0;
    @(negedge clk_i);
    flush_all_i = 1'b0; fill_valid_i = 1'b0;
    chk("R11", 20'h500, 4'd1, 1'b1, 1'b0, '0, 1'b0);
    // R11: fill dropped alongside a single-page flush
    @(negedge clk_i);
    flush_page_i = 1'b1; flush_vpn_i = 20'h777; fill_valid_i = 1'b1; fill_vpn_i = 20'h501;
    @(negedge clk_i);
    flush_page_i = 1'b0; fill_valid_i = 1'b0;
    chk("R11", 20'h501, 4'd1, 1'b1, 1'b0, '0, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule